// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion Status

This block holds the event, mask and completion state of one simple DMA channel. A data movement engine sends it single-cycle pulses: one per event source, a pulse when a transfer starts, and a pulse when a transfer completes. Software reaches the block through a 32-bit register port that takes only whole words. Through that port it reads the latched events and clears them. It opens or closes the interrupt mask through two write-only ports, and it reads a busy flag and a small completion counter.

The interrupt line is a level. It is high while at least one latched event is not masked. Every source starts masked after reset. The completion counter counts finished transfers that software has not yet acknowledged. Software acknowledges a transfer by clearing the DONE event.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, the latched events read 0x00, the mask reads 0xFF, the counter and the busy flag read 0, and `irq_o` is low.
- R2: The event register sits at word offset 1. Bit 7 is FIFO overflow, bit 6 invalid register access, bit 5 threshold hit, bit 4 memory timeout, bit 3 stream timeout, bit 2 bus response error, bit 1 DONE and bit 0 MEM_DONE. An `evt_i` bit sets the matching event bit. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R3: Writing 1 to a bit at offset 2 (enable) clears that mask bit. Writing 1 to a bit at offset 3 (disable) sets it. Zero bits have no effect. Both offsets read back as 0.
- R4: The mask is read at offset 4, and writes to offset 4 have no effect.
- R5: `irq_o` is high exactly when some event bit is set while its mask bit is clear.
- R6: An event that arrives in the same cycle as a software clear of the same bit wins, and the bit stays set.
- R7: The status word at offset 0 carries the busy flag at bit 0 and a 3-bit completion counter at bits 15..13. A completion pulse increments the counter, and the counter wraps modulo 8.
- R8: A write that clears DONE while DONE is set decrements the counter, wrapping modulo 8. A DONE clear when DONE is already clear leaves the counter unchanged. An increment and a decrement in the same cycle cancel.
- R9: A start pulse sets busy and a completion pulse clears it. When both arrive in the same cycle, busy ends clear.
- R10: A completion sets DONE. With READ_CHANNEL=1 (the default) it also sets MEM_DONE.
- R11: Read data appears on `rd_data_o` in the cycle after `rd_en_i`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, one cycle after the read strobe |
| evt_i | input | 8 | Event pulses from the engine |
| xfer_start_i | input | 1 | Transfer start pulse |
| xfer_done_i | input | 1 | Transfer completion pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
The hardest situations to reach are the same-cycle races. The first is an engine event or completion landing in the same cycle as a software clear of that bit. The second is a start and a completion arriving together. The bench drives the strobe and the pulses at the same falling edge, so the block sees them at one rising edge. It then reads back the event bits, the counter and busy. The counter's downward wrap is reached by first wrapping it up to 0 with a run of completions and then clearing DONE once.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int ADDR_W       = 3,
  parameter int CNT_W        = 3,
  parameter int CNT_LSB      = 13,
  parameter bit READ_CHANNEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  input  logic [7:0]        evt_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic              irq_o
);
  localparam int NSRC = 8;
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_EVT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_DIS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(4);
  localparam int DONE_BIT = 1;

  logic [NSRC-1:0]  evt_q, mask_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  wire unused_wdata = ^wdata_i[31:NSRC];

  wire [NSRC-1:0] wbits    = wdata_i[NSRC-1:0];
  wire            wr_evt   = wr_en_i && (addr_i == OFF_EVT);
  wire            wr_en_m  = wr_en_i && (addr_i == OFF_EN);
  wire            wr_dis_m = wr_en_i && (addr_i == OFF_DIS);
  wire [NSRC-1:0] done_set = {{(NSRC-2){1'b0}}, 1'b1, READ_CHANNEL};
  wire [NSRC-1:0] set_vec  = evt_i | (xfer_done_i ? done_set : '0);
  wire [NSRC-1:0] clr_vec  = wr_evt ? wbits : '0;
  wire            cnt_dec  = wr_evt && wbits[DONE_BIT] && evt_q[DONE_BIT];
  wire            cnt_inc  = xfer_done_i;

  assign irq_o = |(evt_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      evt_q <= (evt_q & ~clr_vec) | set_vec;
      if (wr_en_m)       mask_q <= mask_q & ~wbits;
      else if (wr_dis_m) mask_q <= mask_q | wbits;
      if (cnt_inc && !cnt_dec)      cnt_q <= cnt_q + 1'b1;
      else if (cnt_dec && !cnt_inc) cnt_q <= cnt_q - 1'b1;
      if (xfer_done_i)       busy_q <= 1'b0;
      else if (xfer_start_i) busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else if (rd_en_i) begin
      case (addr_i)
        OFF_STAT: rd_data_o <= (32'(cnt_q) << CNT_LSB) | 32'(busy_q);
        OFF_EVT:  rd_data_o <= 32'(evt_q);
        OFF_MASK: rd_data_o <= 32'(mask_q);
        default:  rd_data_o <= '0;
      endcase
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ((wbits & ~set_vec) != '0)) |=> ((evt_q & $past(wbits & ~set_vec)) == '0)); // R2
  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_m |=> ((mask_q & $past(wbits)) == $past(wbits))); // R3
  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFF_MASK) |=> $stable(mask_q)); // R4
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((evt_q & $past(set_vec)) == $past(set_vec))); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1) || cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> !busy_q); // R9
endmodule

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0] evt = 0;
  logic xstart = 0, xdone = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma_irq_status dut (.clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rdata), .evt_i(evt),
    .xfer_start_i(xstart), .xfer_done_i(xdone), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] e, input logic s, input logic dn);
    @(negedge clk); evt = e; xstart = s; xdone = dn;
    @(negedge clk); evt = 0; xstart = 0; xdone = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 status word", v, 32'h0);
    rd(3'd1, v); check("R1 events", v, 32'h0);
    rd(3'd4, v); check("R1 mask", v, 32'hFF);
    check("R1 irq", irq, 0);
    rd(3'd6, v); check("R11 unmapped", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pulse(8'hFC, 0, 0);
    rd(3'd1, v); check("R2 events set", v, 32'hFC);
    wr(3'd1, 32'h84);
    rd(3'd1, v); check("R2 w1c", v, 32'h78);
    wr(3'd1, 32'h0);
    rd(3'd1, v); check("R2 zero write", v, 32'h78);
    wr(3'd1, 32'hFF);
    rd(3'd1, v); check("R2 clear all", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pulse(8'h20, 0, 0);
    check("R5 masked pending", irq, 0);
    wr(3'd2, 32'h20);
    check("R5 unmasked irq", irq, 1);
    rd(3'd4, v); check("R3 enable", v, 32'hDF);
    rd(3'd2, v); check("R3 enable reads 0", v, 32'h0);
    wr(3'd3, 32'h20);
    check("R5 remasked", irq, 0);
    rd(3'd4, v); check("R3 disable", v, 32'hFF);
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R4 mask read-only", v, 32'hFF);
    wr(3'd1, 32'hFF);
  endtask

  task automatic t_done();
    logic [31:0] v;
    pulse(0, 0, 1);
    rd(3'd1, v); check("R10 done flags", v, 32'h03);
    rd(3'd0, v); check("R7 count 1", v, 32'h2000);
    pulse(0, 1, 0);
    rd(3'd0, v); check("R9 busy set", v, 32'h2001);
    pulse(0, 0, 1);
    rd(3'd0, v); check("R9 busy cleared R7 count 2", v, 32'h4000);
    wr(3'd1, 32'h2);
    rd(3'd0, v); check("R8 decrement", v, 32'h2000);
    rd(3'd1, v); check("R2 done cleared", v, 32'h01);
    wr(3'd1, 32'h2);
    rd(3'd0, v); check("R8 no decrement when clear", v, 32'h2000);
    wr(3'd1, 32'hFF);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    for (int i = 0; i < 7; i++) pulse(0, 0, 1);
    rd(3'd0, v); check("R7 wrap up", v, 32'h0);
    wr(3'd1, 32'hFF);
    rd(3'd0, v); check("R8 wrap down", v, 32'hE000);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pulse(0, 0, 1);
    @(negedge clk); evt = 8'h40; xdone = 1; wr_en = 1; addr = 3'd1; wdata = 32'h42;
    @(negedge clk); evt = 0; xdone = 0; wr_en = 0;
    rd(3'd1, v); check("R6 event wins", v, 32'h43);
    rd(3'd0, v); check("R8 inc and dec cancel", v, 32'h0);
    @(negedge clk); xstart = 1; xdone = 1;
    @(negedge clk); xstart = 0; xdone = 0;
    rd(3'd0, v); check("R9 start and done together", v, 32'h2000);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_w1c();
    t_mask();
    t_done();
    t_wrap();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule